// File: doc/BRIEF.md
# Page-Write Address Counter and Commit Engine

This block sits behind a two-wire serial memory front end. It keeps the word-address pointer for an 8192-byte array arranged as 256 pages of 32 bytes. It also gathers the bytes of a write transaction in a one-page staging buffer and runs the timed commit that moves them into the storage array. The protocol front end only sends it simple strobes: an address load, a received write byte, a read advance and a stop.

Writes move only the low five pointer bits, so the pointer circles within its page. Reads move the whole pointer and wrap at the end of the array. A commit starts only at a stop that ends a transaction with at least one received byte. While it runs, a busy window of a fixed number of clock cycles is open, and only the bytes that were actually received reach the array. A write-protect input guards the top quarter of the address space.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, `cur_addr` is 0, `busy` is 0 and `mem_we` is 0.
- R2: When not busy, `addr_load` sets `cur_addr` to `addr_val` in the next cycle and discards any bytes staged since the last stop or load.
- R3: When not busy, each `wr_strobe` stages `wr_data` at offset `cur_addr[4:0]` and increments only `cur_addr[4:0]` (offset 31 goes to 0). Bits [12:5] are unchanged.
- R4: If more than 32 bytes arrive in one transaction, a later byte replaces the earlier byte at the same offset, and each offset is committed at most once.
- R5: When not busy, `rd_adv` increments the full 13-bit `cur_addr`, wrapping from 0x1FFF to 0x0000.
- R6: A `stop` with at least one staged byte on an unprotected page raises `busy` in the cycle after the stop. `busy` stays high for exactly `COMMIT_CYCLES` cycles.
- R7: During the first 32 cycles of a commit, `mem_we` pulses once for each staged offset only, in ascending offset order. `mem_addr` is {page bits [12:5] of `cur_addr`, offset} and `mem_wdata` is the staged byte. `mem_we` is never high outside `busy`.
- R8: With `wp` high at the stop, a transaction whose page lies in 0x1800..0x1FFF (`cur_addr[12:11]` == 2'b11) is discarded, with no `busy` and no `mem_we`. Pages below 0x1800, or any page with `wp` low, commit normally.
- R9: A `stop` with no staged bytes does not raise `busy` and causes no `mem_we`.
- R10: While `busy` is high, `addr_load`, `wr_strobe`, `rd_adv` and `stop` have no effect on `cur_addr`, the staged bytes or the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load pointer and start a new transaction |
| addr_val | input | 13 | Address loaded by `addr_load` |
| wr_strobe | input | 1 | One received write byte |
| wr_data | input | 8 | Byte that goes with `wr_strobe` |
| rd_adv | input | 1 | Advance pointer after a read byte |
| stop | input | 1 | End of transaction |
| wp | input | 1 | Protect top quarter of the array |
| cur_addr | output | 13 | Current word-address pointer |
| busy | output | 1 | Commit window open |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The scoreboard runs a single-byte write and a partial write that crosses a page end. The second one shows whether the offset wraps inside the page and whether only received offsets are written. A 33-byte burst checks overwrite against a double commit. Protected and unprotected pages around 0x1800, under both `wp` levels, exercise the guard boundary. An empty stop, a read advance across 0x1FFF, a reload that drops staged bytes, and strobes issued during a busy window check the cases where the pointer must or must not move.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W     = 13;
  localparam int OFF_W      = 5;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int DATA_W     = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DATA_W-1:0] byte_t;

  // next pointer after a written byte: only the in-page offset moves
  function automatic addr_t next_in_page(input addr_t a);
    off_t o;
    o = a[OFF_W-1:0] + off_t'(1);
    return {a[ADDR_W-1:OFF_W], o};
  endfunction

  // next pointer after a read byte: whole array, natural wrap
  function automatic addr_t next_in_array(input addr_t a);
    return a + addr_t'(1);
  endfunction

  // top quarter of the array is guarded when wp is high
  function automatic logic is_guarded(input addr_t a, input logic wp);
    return wp && (&a[ADDR_W-1:ADDR_W-2]);
  endfunction
endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr
  import pgw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  load,
  input  addr_t load_val,
  input  logic  wr,
  input  logic  rd,
  output addr_t addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (accept) begin
      if (load)    addr <= load_val;
      else if (wr) addr <= next_in_page(addr);
      else if (rd) addr <= next_in_array(addr);
    end
  end
endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
  import pgw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  wr_en,
  input  off_t  wr_off,
  input  byte_t wr_byte,
  input  off_t  rd_off,
  output byte_t rd_byte,
  output logic  rd_valid,
  output logic  any_valid
);
  byte_t                 slot  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[i]  <= '0;
        valid[i] <= 1'b0;
      end else if (clr) begin
        valid[i] <= 1'b0;
      end else if (wr_en && (wr_off == off_t'(i))) begin
        slot[i]  <= wr_byte;
        valid[i] <= 1'b1;
      end
    end
  end

  assign rd_byte   = slot[rd_off];
  assign rd_valid  = valid[rd_off];
  assign any_valid = |valid;
endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq
  import pgw_pkg::*;
#(
  parameter int COMMIT_CYCLES = 250000   // must be >= PAGE_BYTES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic scan_phase,
  output off_t scan_off
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(COMMIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign done       = busy && (cnt == LAST);
  assign scan_phase = busy && (cnt < CW'(PAGE_BYTES));
  assign scan_off   = cnt[OFF_W-1:0];
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int COMMIT_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [12:0]       addr_val,
  input  logic              wr_strobe,
  input  logic [7:0]        wr_data,
  input  logic              rd_adv,
  input  logic              stop,
  input  logic              wp,
  output logic [12:0]       cur_addr,
  output logic              busy,
  output logic              mem_we,
  output logic [12:0]       mem_addr,
  output logic [7:0]        mem_wdata
);
  logic  accept_w, start_w, done_w, clr_w, wr_en_w;
  logic  scan_phase_w, rd_valid_w, any_valid_w;
  off_t  scan_off_w;
  byte_t rd_byte_w;

  assign accept_w = !busy;
  assign wr_en_w  = accept_w && wr_strobe && !addr_load;
  assign start_w  = accept_w && stop && any_valid_w && !is_guarded(cur_addr, wp);
  assign clr_w    = done_w || (accept_w && (addr_load || (stop && !start_w)));

  pgw_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .accept(accept_w),
    .load(addr_load), .load_val(addr_val),
    .wr(wr_strobe), .rd(rd_adv), .addr(cur_addr)
  );

  pgw_page_buf u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr_w),
    .wr_en(wr_en_w), .wr_off(cur_addr[OFF_W-1:0]), .wr_byte(wr_data),
    .rd_off(scan_off_w), .rd_byte(rd_byte_w), .rd_valid(rd_valid_w),
    .any_valid(any_valid_w)
  );

  pgw_commit_seq #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w),
    .busy(busy), .done(done_w),
    .scan_phase(scan_phase_w), .scan_off(scan_off_w)
  );

  // pointer page is frozen while busy, so it names the committed page
  assign mem_we    = scan_phase_w && rd_valid_w;
  assign mem_addr  = {cur_addr[ADDR_W-1:OFF_W], scan_off_w};
  assign mem_wdata = rd_byte_w;
endmodule

// File: rtl/pgw_commit_chk.sv
module pgw_commit_chk #(
  parameter int COMMIT_CYCLES = 250000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stop,
  input logic        wr_strobe,
  input logic        addr_load,
  input logic        busy,
  input logic        mem_we,
  input logic [12:0] mem_addr,
  input logic [12:0] cur_addr
);
  localparam int CW = $clog2(COMMIT_CYCLES + 2);
  logic [CW-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win <= '0;
    else if (busy) win <= win + CW'(1);
    else           win <= '0;
  end

  assert_we_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[4:0] > $past(mem_addr[4:0])));

  assert_start_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && win != '0) |-> (win == CW'(COMMIT_CYCLES)));

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !addr_load && !busy) |=> (cur_addr[12:5] == $past(cur_addr[12:5])));

  assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cur_addr));
endmodule

bind pgw_ctrl pgw_commit_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .wr_strobe(wr_strobe),
  .addr_load(addr_load), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .cur_addr(cur_addr)
);

// File: tb/pgw_ctrl_test.sv
`timescale 1ns/1ps
module pgw_ctrl_test;
  localparam int CC = 40;

  logic clk = 0, rst_n = 0;
  logic addr_load = 0, wr_strobe = 0, rd_adv = 0, stop = 0, wp = 0;
  logic [12:0] addr_val = 0;
  logic [7:0]  wr_data = 0;
  logic [12:0] cur_addr, mem_addr;
  logic [7:0]  mem_wdata;
  logic busy, mem_we;

  int checks = 0, fails = 0;
  logic [20:0] expq[$];   // {addr, data}

  // bench model of the transaction
  logic [12:0] m_addr;
  logic [7:0]  m_data [32];
  logic        m_val  [32];

  always #10 clk = ~clk;

  pgw_ctrl #(.COMMIT_CYCLES(CC)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every array write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R7 actual=%h expected=none", {mem_addr, mem_wdata});
      end else begin
        logic [20:0] e;
        e = expq.pop_front();
        if (e !== {mem_addr, mem_wdata}) begin
          fails++;
          $display("FAIL R7 actual=%h expected=%h", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic do_load(input logic [12:0] a);
    @(negedge clk); addr_load = 1; addr_val = a;
    @(negedge clk); addr_load = 0;
    m_addr = a;
    for (int i = 0; i < 32; i++) m_val[i] = 0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); wr_strobe = 1; wr_data = d;
    @(negedge clk); wr_strobe = 0;
    m_data[m_addr[4:0]] = d; m_val[m_addr[4:0]] = 1;
    m_addr[4:0] = m_addr[4:0] + 5'd1;
  endtask

  task automatic do_rd;
    @(negedge clk); rd_adv = 1;
    @(negedge clk); rd_adv = 0;
    m_addr = m_addr + 13'd1;
  endtask

  // stop; returns the measured busy length
  task automatic do_stop(output int blen);
    logic any;
    any = 0;
    for (int i = 0; i < 32; i++) any |= m_val[i];
    if (any && !(wp && m_addr[12:11] == 2'b11))
      for (int i = 0; i < 32; i++)
        if (m_val[i]) expq.push_back({m_addr[12:5], i[4:0], m_data[i]});
    for (int i = 0; i < 32; i++) m_val[i] = 0;
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bl;
    m_addr = 0;
    for (int i = 0; i < 32; i++) begin m_val[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 addr", cur_addr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 we", mem_we, 0);
    rst_n = 1;

    // single byte
    do_load(13'h0123);
    chk("R2 load", cur_addr, 13'h0123);
    do_wr(8'hAA);
    chk("R3 inc", cur_addr, 13'h0124);
    do_stop(bl);
    chk("R6 busy len", bl, CC);
    chk("R7 drained", expq.size(), 0);

    // partial write across page end: offsets 30,31,0
    do_load(13'h005E);
    do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
    chk("R3 wrap in page", cur_addr, 13'h0041);
    do_stop(bl);
    chk("R6 busy len", bl, CC);
    chk("R7 drained", expq.size(), 0);

    // 33 bytes: offset 0 overwritten
    do_load(13'h0100);
    for (int i = 0; i < 33; i++) do_wr(8'(i + 8'h40));
    chk("R4 addr", cur_addr, 13'h0101);
    do_stop(bl);
    chk("R4 drained", expq.size(), 0);

    // read advance wrap
    do_load(13'h1FFE);
    do_rd;
    chk("R5 inc", cur_addr, 13'h1FFF);
    do_rd;
    chk("R5 wrap", cur_addr, 13'h0000);

    // reload drops staged bytes
    do_load(13'h0200); do_wr(8'h5A);
    do_load(13'h0300); do_wr(8'hA5);
    do_stop(bl);
    chk("R2 discard", expq.size(), 0);

    // protection
    wp = 1;
    do_load(13'h1800); do_wr(8'h77);
    do_stop(bl);
    chk("R8 guarded no busy", bl, 0);
    chk("R8 guarded addr", cur_addr, 13'h1801);
    do_load(13'h17FF); do_wr(8'h78);
    do_stop(bl);
    chk("R8 below edge", bl, CC);
    wp = 0;
    do_load(13'h1FF0); do_wr(8'h79);
    do_stop(bl);
    chk("R8 wp low", bl, CC);
    chk("R8 drained", expq.size(), 0);

    // empty stop
    do_load(13'h0400);
    do_stop(bl);
    chk("R9 no busy", bl, 0);

    // strobes during busy are ignored
    do_load(13'h0500); do_wr(8'hC3);
    expq.push_back({13'h0500, 8'hC3});
    for (int i = 0; i < 32; i++) m_val[i] = 0;
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    chk("R6 busy rise", busy, 1);
    @(negedge clk); addr_load = 1; addr_val = 13'h0ABC;
    @(negedge clk); addr_load = 0; wr_strobe = 1; wr_data = 8'hEE;
    @(negedge clk); wr_strobe = 0; rd_adv = 1;
    @(negedge clk); rd_adv = 0; stop = 1;
    @(negedge clk); stop = 0;
    chk("R10 addr held", cur_addr, 13'h0501);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 no extra busy", busy, 0);
    chk("R10 addr after", cur_addr, 13'h0501);
    chk("R10 drained", expq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule